// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This always-on controller sits on a simple 32-bit register bus, clocked by the slow clock. It drives `power_en`, which switches the main supply. Software turns the supply off by writing a shutdown command. The command only takes effect when the top byte of the write carries the password. The supply comes back on when an enabled wake-up source qualifies. A status register then tells software which source caused the wake.

There are three wake-up sources: an external wake pin, a real-time-timer alarm pulse and a real-time-clock alarm pulse.

- The pin can wake on a high level, on a low level, or on any change away from the level it had when the supply went off. The pin condition must hold for a programmable number of cycles before it counts.
- Each timer alarm has its own enable bit.

The controller is built around a two-state machine:

- **ST_ON**: the supply is enabled. This is the reset state.
- **ST_OFF**: the supply is off.

It has two transitions:

- **T_SHUTDOWN**: from ST_ON to ST_OFF, on a keyed shutdown write. At the same edge the wake pin's synchronized level is captured as the reference for any-level mode.
- **T_WAKE**: from ST_OFF to ST_ON, on any qualified wake source. At the same edge the status bits of the sources that fired are set.

Register offsets (byte addresses on `bus_addr`):

| Offset | Register |
|--------|----------|
| 0x0 | control |
| 0x4 | mode |
| 0x8 | status |

Top module: `sdw_ctrl`

## Requirements
- R1: After reset `power_en` is 1, the status register reads 0x00000000 and the mode register reads 0x00000003 (any-level pin mode, count 0, both timer wake-ups disabled).
- R2: A write to offset 0x0 with bits 31:24 = 0xA5 and bit 0 = 1 moves ST_ON to ST_OFF, so `power_en` is 0 after that clock edge.
- R3: A write to offset 0x0 with any other key, or with bit 0 = 0, has no effect and `power_en` stays 1.
- R4: The mode register at offset 0x4 stores these fields, and every other bit reads 0:
  - bits 2:0: pin mode
  - bits 7:4: debounce count N
  - bit 16: real-time-timer wake enable
  - bit 17: real-time-clock wake enable
- R5: The pin modes are:
  - 1: the synchronized pin is 1
  - 2: the synchronized pin is 0
  - 3: the synchronized pin differs from its level captured at T_SHUTDOWN
  - 0, and codes 4 to 7: the pin never wakes
- R6: The pin passes through two flops. The condition must hold for N+1 consecutive synchronized cycles. In ST_OFF, with the pin condition met from a pin change, `power_en` is still 0 after N+2 clock edges and is 1 after N+3 edges. If the condition drops earlier, the count restarts from zero.
- R7: In ST_OFF, a real-time-timer alarm sampled high at an edge wakes if bit 16 is set, and a real-time-clock alarm wakes if bit 17 is set. An alarm whose enable bit is clear is ignored.
- R8: At T_WAKE, status bit 0 (pin), bit 16 (real-time timer) or bit 17 (real-time clock) is set only for the sources that qualified at that edge.
- R9: A read of offset 0x8 returns the status and clears it at that clock edge.
- R10: In ST_ON, pin and alarm events set no status bits and leave `power_en` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wake_pin | input | 1 | External wake pin, asynchronous |
| rtt_alarm | input | 1 | Real-time-timer alarm pulse |
| rtc_alarm | input | 1 | Real-time-clock alarm pulse |
| power_en | output | 1 | Main supply enable |

## Verification
The bench builds the block with its defaults:

- `ADDR_W` = 4, which covers all three register offsets.
- `SYNC_STAGES` = 2, which fixes the wake latency at N+3 edges after a pin change.

A table of six pin cases walks through:

- high, low and any-level modes
- both reference levels
- debounce counts from 0 up to the maximum of 15

Directed tests then cover the key checks, the disabled pin mode, each timer alarm, a debounce that is interrupted and restarted, and events that arrive while the supply is on.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int          DATA_W   = 32;
    localparam int          CNT_W    = 4;
    localparam int          OFS_CTRL = 0;
    localparam int          OFS_MODE = 4;
    localparam int          OFS_STAT = 8;
    localparam logic [7:0]  SHDN_KEY = 8'hA5;

    typedef enum logic [0:0] {
        ST_ON  = 1'b0,
        ST_OFF = 1'b1
    } pwr_state_e;

    typedef enum logic [2:0] {
        PM_NONE = 3'd0,
        PM_HIGH = 3'd1,
        PM_LOW  = 3'd2,
        PM_ANY  = 3'd3
    } pin_mode_e;

    typedef struct packed {
        logic             rtc_en;
        logic             rtt_en;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       pmode;
    } mode_t;

    // Wake source vector: bit 0 pin, bit 1 real-time timer, bit 2 real-time clock
    localparam int SRC_N = 3;

endpackage

// File: rtl/sdw_regs.sv
module sdw_regs
    import sdw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  wake_set,
    output mode_t             mode_q,
    output logic [SRC_N-1:0]  stat_q,
    output logic              shdn_req
);

    logic hit_ctrl, hit_mode, hit_stat;
    logic wr_mode, rd_stat;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));

    assign wr_mode  = bus_sel && bus_wr && hit_mode;
    assign rd_stat  = bus_sel && !bus_wr && hit_stat;

    // Keyed command: password in the top byte plus the command bit
    assign shdn_req = bus_sel && bus_wr && hit_ctrl
                      && (bus_wdata[31:24] == SHDN_KEY) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.pmode  <= PM_ANY;
            mode_q.cnt    <= '0;
            mode_q.rtt_en <= 1'b0;
            mode_q.rtc_en <= 1'b0;
        end else if (wr_mode) begin
            mode_q.pmode  <= bus_wdata[2:0];
            mode_q.cnt    <= bus_wdata[4 +: CNT_W];
            mode_q.rtt_en <= bus_wdata[16];
            mode_q.rtc_en <= bus_wdata[17];
        end
    end

    // New wake flags win over a clearing read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_stat ? '0 : stat_q) | wake_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_mode) begin
                bus_rdata[2:0]         = mode_q.pmode;
                bus_rdata[4 +: CNT_W]  = mode_q.cnt;
                bus_rdata[16]          = mode_q.rtt_en;
                bus_rdata[17]          = mode_q.rtc_en;
            end else if (hit_stat) begin
                bus_rdata[0]  = stat_q[0];
                bus_rdata[16] = stat_q[1];
                bus_rdata[17] = stat_q[2];
            end
        end
    end

endmodule

// File: rtl/sdw_pin_qual.sv
module sdw_pin_qual
    import sdw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_pin,
    input  logic [2:0]       pmode,
    input  logic [CNT_W-1:0] limit,
    input  logic             arm,
    input  logic             capture,
    output logic             pin_hit
);

    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   ref_q;
    logic                   cond;
    logic [CNT_W-1:0]       run_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= wake_pin;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Reference level for any-change mode, taken when the supply goes off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_q <= 1'b0;
        else if (capture) ref_q <= pin_s;
    end

    always_comb begin
        case (pmode)
            PM_HIGH: cond = pin_s;
            PM_LOW:  cond = !pin_s;
            PM_ANY:  cond = (pin_s != ref_q);
            default: cond = 1'b0;
        endcase
    end

    // Consecutive-cycle counter, restarted whenever the condition drops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!arm || !cond) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign pin_hit = arm && cond && (run_q >= limit);

endmodule

// File: rtl/sdw_fsm.sv
module sdw_fsm
    import sdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn_req,
    input  logic             pin_hit,
    input  logic             rtt_alarm,
    input  logic             rtc_alarm,
    input  logic             rtt_en,
    input  logic             rtc_en,
    output logic             power_en,
    output logic             arm,
    output logic             capture,
    output logic [SRC_N-1:0] wake_set
);

    pwr_state_e       state_q, state_d;
    logic [SRC_N-1:0] src_hit;

    assign src_hit = {rtc_alarm && rtc_en, rtt_alarm && rtt_en, pin_hit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:  if (shdn_req)    state_d = ST_OFF;  // T_SHUTDOWN
            ST_OFF: if (|src_hit)    state_d = ST_ON;   // T_WAKE
            default:                 state_d = ST_ON;
        endcase
    end

    always_comb begin
        power_en = 1'b1;
        arm      = 1'b0;
        capture  = 1'b0;
        wake_set = '0;
        unique case (state_q)
            ST_ON: begin
                capture = shdn_req;
            end
            ST_OFF: begin
                power_en = 1'b0;
                arm      = 1'b1;
                wake_set = src_hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wake_pin,
    input  logic              rtt_alarm,
    input  logic              rtc_alarm,
    output logic              power_en
);

    mode_t            mode_q;
    logic [SRC_N-1:0] stat_q;
    logic [SRC_N-1:0] wake_set;
    logic             shdn_req;
    logic             pin_hit;
    logic             arm;
    logic             capture;

    sdw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_set  (wake_set),
        .mode_q    (mode_q),
        .stat_q    (stat_q),
        .shdn_req  (shdn_req)
    );

    sdw_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_pin (wake_pin),
        .pmode    (mode_q.pmode),
        .limit    (mode_q.cnt),
        .arm      (arm),
        .capture  (capture),
        .pin_hit  (pin_hit)
    );

    sdw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .shdn_req  (shdn_req),
        .pin_hit   (pin_hit),
        .rtt_alarm (rtt_alarm),
        .rtc_alarm (rtc_alarm),
        .rtt_en    (mode_q.rtt_en),
        .rtc_en    (mode_q.rtc_en),
        .power_en  (power_en),
        .arm       (arm),
        .capture   (capture),
        .wake_set  (wake_set)
    );

endmodule

// File: rtl/sdw_ctrl_chk.sv
module sdw_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              power_en,
    input logic [2:0]        stat_q
);

    logic ctrl_wr, good_cmd, stat_rd;

    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign good_cmd = ctrl_wr && (bus_wdata[31:24] == 8'hA5) && bus_wdata[0];
    assign stat_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(8));

    // R2
    shdn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && good_cmd) |=> !power_en);

    // R3
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && ctrl_wr && !good_cmd) |=> power_en);

    // R10
    on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && !stat_rd) |=> $stable(stat_q));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && stat_rd) |=> (stat_q == 3'b000));

    // R8
    wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_en) |-> (stat_q != 3'b000));

endmodule

bind sdw_ctrl sdw_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .power_en  (power_en),
    .stat_q    (stat_q)
);

// File: tb/sim_sdw_ctrl.sv
module sim_sdw_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int N_VEC      = 6;

    // Each entry: {pin mode[2:0], debounce count[3:0], idle pin level}
    localparam logic [7:0] VEC [N_VEC] = '{
        {3'd1, 4'd0,  1'b0},
        {3'd2, 4'd3,  1'b1},
        {3'd3, 4'd15, 1'b0},
        {3'd3, 4'd2,  1'b1},
        {3'd1, 4'd7,  1'b0},
        {3'd2, 4'd0,  1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wake_pin = 1'b0;
    logic              rtt_alarm = 1'b0;
    logic              rtc_alarm = 1'b0;
    logic              power_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdw_ctrl #(.ADDR_W(ADDR_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_pin  (wake_pin),
        .rtt_alarm (rtt_alarm),
        .rtc_alarm (rtc_alarm),
        .power_en  (power_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_rtt();
        rtt_alarm = 1'b1; @(negedge clk); rtt_alarm = 1'b0;
    endtask

    task automatic pulse_rtc();
        rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 power_en", {31'b0, power_en}, 32'h1);
        bus_read(4'h8, rd); chk("R1 status", rd, 32'h0);
        bus_read(4'h4, rd); chk("R1 mode", rd, 32'h3);

        // Table of pin cases: R2, R4, R5, R6, R8, R9
        for (int i = 0; i < N_VEC; i++) begin
            logic [2:0] pm;
            logic [3:0] nc;
            logic       idle;
            {pm, nc, idle} = VEC[i];
            wake_pin = idle;
            bus_write(4'h4, {24'h0, nc, 1'b0, pm});
            tick(3);
            bus_read(4'h4, rd); chk("R4 mode readback", rd, {24'h0, nc, 1'b0, pm});
            bus_write(4'h0, 32'hA500_0001);
            chk("R2 shutdown", {31'b0, power_en}, 32'h0);
            wake_pin = ~idle;
            tick(int'(nc) + 2);
            chk("R6 still off before count", {31'b0, power_en}, 32'h0);
            tick(1);
            chk("R5 pin wake", {31'b0, power_en}, 32'h1);
            bus_read(4'h8, rd); chk("R8 pin status", rd, 32'h1);
            bus_read(4'h8, rd); chk("R9 cleared", rd, 32'h0);
        end

        // R3 wrong key, and right key without command bit
        bus_write(4'h0, 32'h5A00_0001);
        chk("R3 wrong key", {31'b0, power_en}, 32'h1);
        bus_write(4'h0, 32'hA500_0000);
        chk("R3 no cmd bit", {31'b0, power_en}, 32'h1);

        // R4 unused bits read zero
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); chk("R4 masked fields", rd, 32'h0003_00F7);

        // R5 pin mode 0 never wakes; R7 timer alarm wakes
        wake_pin = 1'b0;
        bus_write(4'h4, 32'h0001_0000);
        tick(3);
        bus_write(4'h0, 32'hA500_0001);
        wake_pin = 1'b1; tick(5); wake_pin = 1'b0; tick(5);
        chk("R5 mode 0 ignores pin", {31'b0, power_en}, 32'h0);
        pulse_rtt();
        chk("R7 rtt wake", {31'b0, power_en}, 32'h1);
        bus_read(4'h8, rd); chk("R8 rtt status only", rd, 32'h0001_0000);

        // R7 disabled alarm ignored, enabled rtc wakes
        bus_write(4'h4, 32'h0002_0000);
        bus_write(4'h0, 32'hA500_0001);
        pulse_rtt(); tick(2);
        chk("R7 disabled rtt ignored", {31'b0, power_en}, 32'h0);
        pulse_rtc();
        chk("R7 rtc wake", {31'b0, power_en}, 32'h1);
        bus_read(4'h8, rd); chk("R8 rtc status only", rd, 32'h0002_0000);

        // R6 interrupted debounce restarts
        wake_pin = 1'b0;
        bus_write(4'h4, 32'h0000_0041);
        tick(3);
        bus_write(4'h0, 32'hA500_0001);
        wake_pin = 1'b1; tick(4); wake_pin = 1'b0; tick(6);
        chk("R6 short pulse rejected", {31'b0, power_en}, 32'h0);
        wake_pin = 1'b1; tick(6);
        chk("R6 restarted count off", {31'b0, power_en}, 32'h0);
        tick(1);
        chk("R6 restarted count wake", {31'b0, power_en}, 32'h1);
        bus_read(4'h8, rd); chk("R8 pin after restart", rd, 32'h1);

        // R10 events while on
        bus_write(4'h4, 32'h0003_0001);
        wake_pin = 1'b1;
        pulse_rtt(); pulse_rtc(); tick(20);
        chk("R10 stays on", {31'b0, power_en}, 32'h1);
        bus_read(4'h8, rd); chk("R10 no status", rd, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule